// File: doc/BRIEF.md
# Privilege-Gated Data Access Guard

This block sits between a processor's data path and its data memory port. It checks every data load and store against the current privilege level. When the processor runs in user mode and a data access targets the low, system-reserved part of the address space, the guard stops the access in the same cycle. The memory sees no strobe, so its contents stay unchanged. Supervisor-mode accesses and accesses above the protected region pass through untouched. Instruction fetches do not travel through this port and are never checked.

On a blocked access the guard raises a one-cycle exception request on the next clock edge. Alongside it the guard presents a fixed exception vector and a return address for the exception entry sequence to save. That address is the incremented PC rewound by one instruction. A return from the handler therefore executes the faulting instruction again. The guard issues one request per faulting access. It issues none while the processor reports that an exception entry is already under way. The entry sequence itself lies outside this block.

Top module: `priv_access_guard`

## Requirements
- R1: After reset, `exc_req_o` is 0, `exc_vec_o` is 0x00 and `save_pc_o` is 0x0000.
- R2: With `user_mode_i`=1 and a strobe active, addresses 0x0000 to 0x2FFF (below the limit 0x3000) are a violation. Addresses 0x3000 to 0xFFFF are not.
- R3: With `user_mode_i`=0, `rd_o` equals `rd_i` and `wr_o` equals `wr_i` for every address, and no request is raised.
- R4: During a violation, `rd_o` and `wr_o` are both 0 in that same cycle. With no violation, they copy `rd_i` and `wr_i`.
- R5: `exc_req_o` is 1 for exactly one cycle, in the cycle after a violation is first seen, even if the violating access is held for several cycles.
- R6: Whenever `exc_req_o` is 1, `exc_vec_o` is 0x02. The vector and `save_pc_o` keep their values until the next request.
- R7: With `exc_req_o`, `save_pc_o` equals the `pc_inc_i` of the violating cycle minus 2, modulo 2^16.
- R8: While `entry_busy_i` is 1, no request is raised. A violation still present once `entry_busy_i` falls raises its request on the following edge.
- R9: With both `rd_i` and `wr_i` at 0, the address alone raises no request, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Data access address |
| rd_i | input | 1 | Load strobe from the data path |
| wr_i | input | 1 | Store strobe from the data path |
| user_mode_i | input | 1 | Privilege bit, 1 = user, 0 = supervisor |
| pc_inc_i | input | 16 | Incremented PC of the current instruction |
| entry_busy_i | input | 1 | Exception entry sequence in progress |
| rd_o | output | 1 | Gated load strobe to memory |
| wr_o | output | 1 | Gated store strobe to memory |
| exc_req_o | output | 1 | Registered one-cycle exception request |
| exc_vec_o | output | 8 | Exception vector captured with the request |
| save_pc_o | output | 16 | Return address captured with the request |

## Verification
The assertions assume that `addr_i`, `pc_inc_i`, the strobes, the mode bit and `entry_busy_i` are stable across each rising edge. They also assume that a violation which should produce a fresh request is preceded by at least one cycle without a violation. The bench drives every input on the falling edge. It separates each swept access by an idle cycle with both strobes low, so each fault counts as a new access. It raises `entry_busy_i` only inside the dedicated hold-off scenario.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int unsigned GUARD_ADDR_W    = 16;
    localparam int unsigned GUARD_VEC_W     = 8;
    localparam int unsigned GUARD_SYS_LIMIT = 32'h3000;
    localparam int unsigned GUARD_EXC_VEC   = 8'h02;
    localparam int unsigned GUARD_INSTR_B   = 2;

    // index of each strobe in the packed strobe vector
    typedef enum logic [0:0] {
        STB_LOAD  = 1'b0,
        STB_STORE = 1'b1
    } strobe_idx_e;
endpackage

// File: rtl/guard_region_cmp.sv
module guard_region_cmp #(
    parameter int unsigned ADDR_W    = guard_pkg::GUARD_ADDR_W,
    parameter int unsigned SYS_LIMIT = guard_pkg::GUARD_SYS_LIMIT
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        stb_i,
    input  logic              user_mode_i,
    output logic              viol_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(SYS_LIMIT);

    logic in_sys;
    logic any_stb;

    always_comb begin
        in_sys  = (addr_i < LIMIT);
        any_stb = |stb_i;
        viol_o  = user_mode_i & any_stb & in_sys;
    end
endmodule

// File: rtl/guard_strobe_gate.sv
module guard_strobe_gate #(
    parameter int unsigned N_STB = 2
) (
    input  logic [N_STB-1:0] stb_i,
    input  logic             block_i,
    output logic [N_STB-1:0] stb_o
);
    for (genvar g = 0; g < N_STB; g++) begin : g_gate
        always_comb begin
            stb_o[g] = stb_i[g] & ~block_i;
        end
    end
endmodule

// File: rtl/guard_exc_reg.sv
module guard_exc_reg #(
    parameter int unsigned ADDR_W  = guard_pkg::GUARD_ADDR_W,
    parameter int unsigned VEC_W   = guard_pkg::GUARD_VEC_W,
    parameter int unsigned EXC_VEC = guard_pkg::GUARD_EXC_VEC,
    parameter int unsigned INSTR_B = guard_pkg::GUARD_INSTR_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] pc_inc_i,
    output logic              req_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [ADDR_W-1:0] save_pc_o
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSTR_B);
    localparam logic [VEC_W-1:0]  VEC_VAL = VEC_W'(EXC_VEC);

    typedef struct packed {
        logic              req;
        logic              flagged;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] pc;
    } exc_state_t;

    exc_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = viol_i & ~busy_i & ~st_q.flagged;
        st_d.req = fire;
        // flag covers the whole violating access; it drops once the access ends
        st_d.flagged = viol_i & (st_q.flagged | fire);
        if (fire) begin
            st_d.vec = VEC_VAL;
            st_d.pc  = pc_inc_i - PC_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o     = st_q.req;
    assign vec_o     = st_q.vec;
    assign save_pc_o = st_q.pc;
endmodule

// File: rtl/priv_access_guard.sv
module priv_access_guard #(
    parameter int unsigned ADDR_W    = guard_pkg::GUARD_ADDR_W,
    parameter int unsigned VEC_W     = guard_pkg::GUARD_VEC_W,
    parameter int unsigned SYS_LIMIT = guard_pkg::GUARD_SYS_LIMIT,
    parameter int unsigned EXC_VEC   = guard_pkg::GUARD_EXC_VEC,
    parameter int unsigned INSTR_B   = guard_pkg::GUARD_INSTR_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              user_mode_i,
    input  logic [ADDR_W-1:0] pc_inc_i,
    input  logic              entry_busy_i,
    output logic              rd_o,
    output logic              wr_o,
    output logic              exc_req_o,
    output logic [VEC_W-1:0]  exc_vec_o,
    output logic [ADDR_W-1:0] save_pc_o
);
    import guard_pkg::*;

    logic [1:0] stb_in;
    logic [1:0] stb_out;
    logic       viol;

    assign stb_in[STB_LOAD]  = rd_i;
    assign stb_in[STB_STORE] = wr_i;

    guard_region_cmp #(
        .ADDR_W    (ADDR_W),
        .SYS_LIMIT (SYS_LIMIT)
    ) u_cmp (
        .addr_i      (addr_i),
        .stb_i       (stb_in),
        .user_mode_i (user_mode_i),
        .viol_o      (viol)
    );

    guard_strobe_gate #(
        .N_STB (2)
    ) u_gate (
        .stb_i   (stb_in),
        .block_i (viol),
        .stb_o   (stb_out)
    );

    guard_exc_reg #(
        .ADDR_W  (ADDR_W),
        .VEC_W   (VEC_W),
        .EXC_VEC (EXC_VEC),
        .INSTR_B (INSTR_B)
    ) u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .viol_i    (viol),
        .busy_i    (entry_busy_i),
        .pc_inc_i  (pc_inc_i),
        .req_o     (exc_req_o),
        .vec_o     (exc_vec_o),
        .save_pc_o (save_pc_o)
    );

    assign rd_o = stb_out[STB_LOAD];
    assign wr_o = stb_out[STB_STORE];
endmodule

// File: rtl/priv_access_guard_chk.sv
module priv_access_guard_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned SYS_LIMIT = 32'h3000,
    parameter int unsigned EXC_VEC   = 8'h02,
    parameter int unsigned INSTR_B   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic              user_mode_i,
    input logic [ADDR_W-1:0] pc_inc_i,
    input logic              entry_busy_i,
    input logic              rd_o,
    input logic              wr_o,
    input logic              exc_req_o,
    input logic [VEC_W-1:0]  exc_vec_o,
    input logic [ADDR_W-1:0] save_pc_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(SYS_LIMIT);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_B);
    localparam logic [VEC_W-1:0]  VEC   = VEC_W'(EXC_VEC);

    p_sup_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode_i |-> (rd_o == rd_i) && (wr_o == wr_i));

    p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode_i && (addr_i < LIMIT)) |-> (!rd_o && !wr_o));

    p_upper_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= LIMIT) |-> (rd_o == rd_i) && (wr_o == wr_i));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |=> !exc_req_o);

    p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> $past(user_mode_i && (rd_i || wr_i) && (addr_i < LIMIT) && !entry_busy_i));

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (exc_vec_o == VEC));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req_o |=> (exc_req_o || ($stable(exc_vec_o) && $stable(save_pc_o))));

    p_save_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (save_pc_o == $past(pc_inc_i) - STEP));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_busy_i |=> !exc_req_o);

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !wr_i) |=> !exc_req_o);
endmodule

bind priv_access_guard priv_access_guard_chk #(
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W),
    .SYS_LIMIT (SYS_LIMIT),
    .EXC_VEC   (EXC_VEC),
    .INSTR_B   (INSTR_B)
) u_chk (.*);

// File: tb/priv_access_guard_test.sv
module priv_access_guard_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LIMIT      = 32'h3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic        user_mode_i = 1'b0;
    logic [15:0] pc_inc_i = '0;
    logic        entry_busy_i = 1'b0;
    logic        rd_o, wr_o, exc_req_o;
    logic [7:0]  exc_vec_o;
    logic [15:0] save_pc_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_access_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .rd_i         (rd_i),
        .wr_i         (wr_i),
        .user_mode_i  (user_mode_i),
        .pc_inc_i     (pc_inc_i),
        .entry_busy_i (entry_busy_i),
        .rd_o         (rd_o),
        .wr_o         (wr_o),
        .exc_req_o    (exc_req_o),
        .exc_vec_o    (exc_vec_o),
        .save_pc_o    (save_pc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access cycle followed by one idle cycle
    task automatic access(input logic [15:0] a, input logic r, input logic w,
                          input logic um, input logic [15:0] pc);
        logic viol;
        logic [15:0] exp_pc;
        viol   = um && (r || w) && (int'(a) < LIMIT);
        exp_pc = pc - 16'd2;
        @(negedge clk);
        addr_i = a; rd_i = r; wr_i = w; user_mode_i = um; pc_inc_i = pc;
        #1;
        chk(um ? "R4 rd gate" : "R3 rd pass", {31'd0, rd_o}, {31'd0, r & ~viol});
        chk(um ? "R4 wr gate" : "R3 wr pass", {31'd0, wr_o}, {31'd0, w & ~viol});
        @(posedge clk); #1;
        chk((r || w) ? "R2 request" : "R9 no strobe", {31'd0, exc_req_o}, {31'd0, viol});
        if (viol) begin
            chk("R6 vector", {24'd0, exc_vec_o}, 32'h02);
            chk("R7 save pc", {16'd0, save_pc_o}, {16'd0, exp_pc});
        end
        @(negedge clk);
        rd_i = 1'b0; wr_i = 1'b0;
        @(posedge clk); #1;
        chk("R5 one cycle", {31'd0, exc_req_o}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] last_pc;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 req reset", {31'd0, exc_req_o}, 32'd0);
        chk("R1 vec reset", {24'd0, exc_vec_o}, 32'd0);
        chk("R1 pc reset",  {16'd0, save_pc_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // sweep: address grid, both modes, all strobe pairs
        for (int a = 0; a < 65536; a += 64) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 4; s++) begin
                    access(16'(a + (a % 61)), s[0], s[1], m[0], 16'(a ^ 16'h5A5A));
                end
            end
        end

        // boundary addresses and PC wrap
        access(16'h2FFF, 1'b1, 1'b0, 1'b1, 16'h3002);
        access(16'h3000, 1'b1, 1'b1, 1'b1, 16'h3004);
        access(16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000);
        access(16'h0001, 1'b1, 1'b0, 1'b1, 16'h0001);
        access(16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h1234);
        access(16'h2FFF, 1'b1, 1'b1, 1'b0, 16'h4444);

        // R6 hold: last captured values stay during idle and supervisor traffic
        access(16'h0100, 1'b0, 1'b1, 1'b1, 16'h3456);
        last_pc = 16'h3454;
        access(16'h0200, 1'b1, 1'b0, 1'b0, 16'h9999);
        chk("R6 vec hold", {24'd0, exc_vec_o}, 32'h02);
        chk("R6 pc hold", {16'd0, save_pc_o}, {16'd0, last_pc});

        // R5: violation held three cycles gives one pulse
        @(negedge clk);
        addr_i = 16'h0400; rd_i = 1'b1; wr_i = 1'b0; user_mode_i = 1'b1; pc_inc_i = 16'h3010;
        @(posedge clk); #1;
        chk("R5 first edge", {31'd0, exc_req_o}, 32'd1);
        @(posedge clk); #1;
        chk("R5 held edge 2", {31'd0, exc_req_o}, 32'd0);
        @(posedge clk); #1;
        chk("R5 held edge 3", {31'd0, exc_req_o}, 32'd0);
        @(negedge clk);
        rd_i = 1'b0;
        @(posedge clk); #1;
        chk("R5 after release", {31'd0, exc_req_o}, 32'd0);

        // R8: busy holds the request off; it fires once busy falls
        @(negedge clk);
        entry_busy_i = 1'b1;
        addr_i = 16'h0800; wr_i = 1'b1; pc_inc_i = 16'h3020;
        @(posedge clk); #1;
        chk("R8 busy edge 1", {31'd0, exc_req_o}, 32'd0);
        chk("R4 blocked under busy", {31'd0, wr_o}, 32'd0);
        @(posedge clk); #1;
        chk("R8 busy edge 2", {31'd0, exc_req_o}, 32'd0);
        @(negedge clk);
        entry_busy_i = 1'b0; pc_inc_i = 16'h3030;
        @(posedge clk); #1;
        chk("R8 late request", {31'd0, exc_req_o}, 32'd1);
        chk("R7 late pc", {16'd0, save_pc_o}, 32'h302E);
        @(negedge clk);
        wr_i = 1'b0;
        @(posedge clk); #1;
        chk("R5 late single", {31'd0, exc_req_o}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule